// File: doc/BRIEF.md
# Interval Timer with Read-Triggered Capture

This block is a 16-bit up-counting interval timer on an 8-bit register bus. A selectable prescaler tap produces the count tick. When the count reaches a programmed compare value on a tick, the counter returns to zero and the block emits a one-cycle interrupt pulse. Software starts and stops the timer through a control register. Stopping the timer clears the count.

Software can sample the running count without stopping the timer. With the capture enable set, a bus read of the capture-low address returns the live low byte of the count. The same read latches the high byte into the capture-high register. A later read of capture-high then returns a high byte that belongs to the same sample as the low byte. While the timer is stopped, a capture-low read returns zero and clears the stored high byte.

The control logic is a two-state machine. In state ST_IDLE the counter is held at zero. In state ST_RUN the counter follows the ticks. Transition START goes from ST_IDLE to ST_RUN: it fires on a control write with the start bit set, provided the mode register selects timer operation. Transition STOP goes from ST_RUN to ST_IDLE: it fires on a control write with the start bit clear.

Top module: `intv_timer`

## Requirements
- R1: After reset the timer is stopped, irq is low and the count is zero. Reads return these values: address 0 (mode) 0x00, address 1 (control) 0x00, address 2 (compare low) 0xFF, address 3 (compare high) 0xFF, address 4 (capture low) 0x00, address 5 (capture high) 0x00, addresses 6 and 7 0x00.
- R2: Mode bits [1:0] select the tick. Code 11 gives a tick every 2 clocks, code 10 every 4, code 01 every 64 and code 00 every 1024. Code 00 with slow_sel high instead gives a tick on every eighth slow_en pulse. The prescaler restarts on START, so the first tick comes one full tick period after the start write.
- R3: On a tick with count equal to the compare value, the count goes to 0x0000 and irq is high for exactly the following clock cycle. The match period is therefore compare+1 ticks.
- R4: A control write (address 1) with bit 0 clear while running stops the timer and clears the count. Afterwards capture-low reads 0x00, control bit 0 reads 0 and no irq occurs.
- R5: Mode writes (address 0, bits [4:0]) are ignored while running. Op field bits [4:2] values 000 and 001 select timer operation. A start write with any other op value leaves the timer stopped.
- R6: With capture enable (control bit 1) set and the timer running, address 4 reads the live count low byte. A read there latches the count high byte of that same cycle into address 5.
- R7: With capture enable set and the timer stopped, address 4 reads 0x00 and a read there clears address 5 to 0x00. Address 5 otherwise holds its value after a stop.
- R8: A control write that clears bit 0 while running leaves the capture-enable bit unchanged, whatever bit 1 of the write holds. Control reads return {capture enable at bit 1, running at bit 0}.
- R9: Address 2 stages the compare low byte. A write to address 3 commits {written byte, staged byte} as the 16-bit compare value. Before that commit, neither matching nor compare reads see the staged byte.
- R10: A control write with bit 0 set while running does not restart or clear the count. Bit 1 of that write still updates capture enable.
- R11: With capture enable clear, address 4 reads 0x00 and a read there leaves address 5 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (causes capture side effects) |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr (combinational) |
| slow_sel | input | 1 | Selects the slow-clock tick for source code 00 |
| slow_en | input | 1 | One-cycle enable per low-speed clock period |
| irq | output | 1 | Compare-match interrupt pulse |

## Verification
The assertions assume that wr_en and rd_en are never high in the same cycle. They also assume that each bus access lasts exactly one cycle, and that slow_en is a single-cycle pulse rather than a level. The stimulus drives every access as a one-cycle strobe, issues reads and writes on separate cycles, and generates slow_en as a pulse every fourth clock. Because irq is required to be separated from the next tick, the properties rely on the shortest tick period being two clocks. The prescaler taps guarantee this.

// File: rtl/intv_timer_pkg.sv
package intv_timer_pkg;
    localparam logic [2:0] A_MODE = 3'd0;
    localparam logic [2:0] A_CTRL = 3'd1;
    localparam logic [2:0] A_CMPL = 3'd2;
    localparam logic [2:0] A_CMPH = 3'd3;
    localparam logic [2:0] A_CAPL = 3'd4;
    localparam logic [2:0] A_CAPH = 3'd5;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    typedef enum logic [1:0] {
        SRC_SLOWEST = 2'b00,
        SRC_SLOW    = 2'b01,
        SRC_FAST    = 2'b10,
        SRC_FASTEST = 2'b11
    } src_sel_e;
endpackage

// File: rtl/intv_prescale.sv
module intv_prescale
    import intv_timer_pkg::*;
#(
    parameter int DIV_A_LOG = 10,
    parameter int DIV_B_LOG = 6,
    parameter int DIV_C_LOG = 2,
    parameter int DIV_D_LOG = 1,
    parameter int SLOW_LOG  = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       run,
    input  logic [1:0] sel,
    input  logic       slow_sel,
    input  logic       slow_en,
    output logic       tick
);
    localparam int PW = DIV_A_LOG;
    localparam logic [PW-1:0] MASK_A = PW'((1 << DIV_A_LOG) - 1);
    localparam logic [PW-1:0] MASK_B = PW'((1 << DIV_B_LOG) - 1);
    localparam logic [PW-1:0] MASK_C = PW'((1 << DIV_C_LOG) - 1);
    localparam logic [PW-1:0] MASK_D = PW'((1 << DIV_D_LOG) - 1);

    logic [PW-1:0]       pre_q;
    logic [SLOW_LOG-1:0] slow_q;
    logic                tap_hit;

    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            pre_q  <= '0;
            slow_q <= '0;
        end else if (run) begin
            pre_q <= pre_q + 1'b1;
            if (slow_en) slow_q <= slow_q + 1'b1;
        end
    end

    always_comb begin
        unique case (src_sel_e'(sel))
            SRC_SLOWEST: tap_hit = slow_sel ? (slow_en && (&slow_q))
                                            : ((pre_q & MASK_A) == MASK_A);
            SRC_SLOW:    tap_hit = (pre_q & MASK_B) == MASK_B;
            SRC_FAST:    tap_hit = (pre_q & MASK_C) == MASK_C;
            SRC_FASTEST: tap_hit = (pre_q & MASK_D) == MASK_D;
            default:     tap_hit = 1'b0;
        endcase
    end

    assign tick = run && tap_hit;
endmodule

// File: rtl/intv_count.sv
module intv_count #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          tick,
    input  logic [CW-1:0] cmp,
    output logic [CW-1:0] cnt_q,
    output logic          irq_q
);
    logic hit;
    assign hit = tick && (cnt_q == cmp);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            irq_q <= 1'b0;
        end else begin
            irq_q <= hit;
            if (clear || hit) cnt_q <= '0;
            else if (tick)    cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/intv_capture.sv
module intv_capture #(
    parameter int DW = 8,
    parameter int CW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sample,
    input  logic          running,
    input  logic [CW-1:0] cnt,
    output logic [DW-1:0] lo_view,
    output logic [DW-1:0] hi_q
);
    assign lo_view = running ? cnt[DW-1:0] : '0;

    always_ff @(posedge clk) begin
        if (!rst_n)      hi_q <= '0;
        else if (sample) hi_q <= running ? cnt[CW-1:DW] : '0;
    end
endmodule

// File: rtl/intv_timer.sv
module intv_timer
    import intv_timer_pkg::*;
#(
    parameter int DW        = 8,
    parameter int DIV_A_LOG = 10,
    parameter int DIV_B_LOG = 6,
    parameter int DIV_C_LOG = 2,
    parameter int DIV_D_LOG = 1,
    parameter int SLOW_LOG  = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [2:0]    addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic          slow_sel,
    input  logic          slow_en,
    output logic          irq
);
    localparam int CW = 2 * DW;

    run_state_e    state_q, state_d;
    logic          running;
    logic [4:0]    mode_q;
    logic          acap_q;
    logic [DW-1:0] stage_q;
    logic [CW-1:0] cmp_q;
    logic [CW-1:0] count_q;
    logic [DW-1:0] cap_hi;
    logic [DW-1:0] cap_lo_view;
    logic          tick;
    logic          ctrl_wr, go, halt, timer_mode, cap_sample;

    assign ctrl_wr    = wr_en && (addr == A_CTRL);
    assign timer_mode = (mode_q[4:3] == 2'b00);
    assign go         = ctrl_wr && wdata[0] && (state_q == ST_IDLE) && timer_mode;
    assign halt       = ctrl_wr && !wdata[0] && (state_q == ST_RUN);
    assign cap_sample = rd_en && (addr == A_CAPL) && acap_q;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (go)   state_d = ST_RUN;
            ST_RUN:  if (halt) state_d = ST_IDLE;
            default:           state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs of the state machine
    always_comb begin
        running = 1'b0;
        unique case (state_q)
            ST_IDLE: running = 1'b0;
            ST_RUN:  running = 1'b1;
            default: running = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= '0;
            acap_q  <= 1'b0;
            stage_q <= '0;
            cmp_q   <= '1;
        end else if (wr_en) begin
            if (addr == A_MODE && !running) mode_q <= wdata[4:0];
            if (ctrl_wr && !halt)           acap_q <= wdata[1];
            if (addr == A_CMPL)             stage_q <= wdata;
            if (addr == A_CMPH)             cmp_q <= {wdata, stage_q};
        end
    end

    intv_prescale #(
        .DIV_A_LOG(DIV_A_LOG), .DIV_B_LOG(DIV_B_LOG), .DIV_C_LOG(DIV_C_LOG),
        .DIV_D_LOG(DIV_D_LOG), .SLOW_LOG(SLOW_LOG)
    ) u_pre (
        .clk(clk), .rst_n(rst_n), .restart(go), .run(running),
        .sel(mode_q[1:0]), .slow_sel(slow_sel), .slow_en(slow_en), .tick(tick)
    );

    intv_count #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clear(go || halt), .tick(tick),
        .cmp(cmp_q), .cnt_q(count_q), .irq_q(irq)
    );

    intv_capture #(.DW(DW), .CW(CW)) u_cap (
        .clk(clk), .rst_n(rst_n), .sample(cap_sample), .running(running),
        .cnt(count_q), .lo_view(cap_lo_view), .hi_q(cap_hi)
    );

    always_comb begin
        case (addr)
            A_MODE:  rdata = DW'(mode_q);
            A_CTRL:  rdata = DW'({acap_q, running});
            A_CMPL:  rdata = cmp_q[DW-1:0];
            A_CMPH:  rdata = cmp_q[CW-1:DW];
            A_CAPL:  rdata = acap_q ? cap_lo_view : '0;
            A_CAPH:  rdata = cap_hi;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/intv_timer_chk.sv
module intv_timer_chk #(
    parameter int DW = 8,
    parameter int CW = 2 * DW
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          rd_en,
    input logic [2:0]    addr,
    input logic          wr_start,
    input logic          irq,
    input logic          running,
    input logic [CW-1:0] cnt,
    input logic [DW-1:0] cap_hi,
    input logic          acap,
    input logic [4:0]    mode
);
    a_r3_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    a_r3_irq_cnt_zero: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (cnt == '0));

    a_r4_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd1 && !wr_start && running) |=> (!running && cnt == '0));

    a_r4_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (cnt == '0));

    a_r2_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running)) |->
            (cnt == $past(cnt) || cnt == $past(cnt) + CW'(1) || cnt == '0));

    a_r5_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running)) |-> $stable(mode));

    a_r6_cap_live: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 3'd4 && acap && running) |=> (cap_hi == $past(cnt[CW-1:DW])));

    a_r7_cap_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 3'd4 && acap && !running) |=> (cap_hi == '0));

    a_r8_acap_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd1 && !wr_start && running) |=> $stable(acap));

    a_r11_cap_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 3'd4 && !acap) |=> $stable(cap_hi));
endmodule

bind intv_timer intv_timer_chk #(.DW(DW), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_start(wdata[0]), .irq(irq), .running(running), .cnt(count_q),
    .cap_hi(cap_hi), .acap(acap_q), .mode(mode_q)
);

// File: tb/test_intv_timer.sv
`timescale 1ns/1ps
module test_intv_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       slow_sel = 1'b0;
    logic       slow_en = 1'b0;
    logic       irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    intv_timer i_intv_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .slow_sel(slow_sel), .slow_en(slow_en),
        .irq(irq)
    );

    // behavioural reference model
    int m_run, m_cnt, m_cmp, m_stage, m_mode, m_acap, m_caphi, m_irq, m_age, m_sc;

    function automatic int period_of(int code);
        case (code)
            0: return 1024;
            1: return 64;
            2: return 4;
            default: return 2;
        endcase
    endfunction

    function automatic int m_read(int a);
        case (a)
            0: return m_mode;
            1: return m_acap * 2 + m_run;
            2: return m_cmp % 256;
            3: return m_cmp / 256;
            4: return (m_acap != 0 && m_run != 0) ? m_cnt % 256 : 0;
            5: return m_caphi;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_cnt = 0; m_cmp = 65535; m_stage = 0; m_mode = 0;
            m_acap = 0; m_caphi = 0; m_irq = 0; m_age = 0; m_sc = 0;
        end else begin
            int per;
            bit tk, slowm;
            int n_cnt, n_irq;
            per   = period_of(m_mode % 4);
            slowm = (m_mode % 4 == 0) && slow_sel;
            tk    = (m_run != 0) && (slowm ? (slow_en && (m_sc % 8 == 7))
                                           : (m_age % per == per - 1));
            n_irq = (tk && m_cnt == m_cmp) ? 1 : 0;
            n_cnt = tk ? ((m_cnt == m_cmp) ? 0 : m_cnt + 1) : m_cnt;
            if (m_run != 0) begin
                m_age++;
                if (slow_en) m_sc++;
            end
            if (rd_en && addr == 3'd4 && m_acap != 0)
                m_caphi = (m_run != 0) ? (m_cnt / 256) : 0;
            if (wr_en) begin
                case (addr)
                    3'd0: if (m_run == 0) m_mode = int'(wdata) % 32;
                    3'd1: begin
                        if (m_run != 0 && !wdata[0]) begin
                            m_run = 0; n_cnt = 0;
                        end else begin
                            m_acap = wdata[1] ? 1 : 0;
                            if (m_run == 0 && wdata[0] && (m_mode / 8) == 0) begin
                                m_run = 1; n_cnt = 0; m_age = 0; m_sc = 0;
                            end
                        end
                    end
                    3'd2: m_stage = int'(wdata);
                    3'd3: m_cmp = int'(wdata) * 256 + m_stage;
                    default: ;
                endcase
            end
            m_cnt = n_cnt;
            m_irq = n_irq;
        end
    end

    task automatic check(string req, int act, int exp, string what);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (rst_n) begin
                string rq;
                case (addr)
                    3'd0: rq = "R5";
                    3'd1: rq = "R8";
                    3'd2, 3'd3: rq = "R9";
                    3'd4: rq = "R6";
                    3'd5: rq = "R7";
                    default: rq = "R1";
                endcase
                check("R3", int'(irq), m_irq, "irq");
                check(rq, int'(rdata), m_read(int'(addr)), "rdata");
            end
        end
    end

    // low-speed enable pulse every 4 clocks
    initial begin
        forever begin
            @(negedge clk); slow_en = 1'b1;
            @(negedge clk); slow_en = 1'b0;
            @(negedge clk);
            @(negedge clk);
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #2 v = int'(rdata);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output int v);
        @(negedge clk);
        addr = a;
        #2 v = int'(rdata);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int v, hi;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        for (int a = 0; a < 8; a++) begin
            peek(3'(a), v);
            check("R1", v, (a == 2 || a == 3) ? 8'hFF : 0, "reset read");
        end
        check("R1", int'(irq), 0, "reset irq");

        // R2: fastest tap, count visible through live capture
        wr(3'd0, 8'h03);
        wr(3'd1, 8'h03);
        repeat (19) @(negedge clk);
        peek(3'd4, v);
        check("R2", v, 10, "count after 20 clocks at div 2");

        // R10: start again while running
        wr(3'd1, 8'h03);
        peek(3'd4, v);
        check("R10", v, 11, "count not restarted");

        // R5: mode locked while running
        wr(3'd0, 8'h01);
        peek(3'd0, v);
        check("R5", v, 8'h03, "mode write ignored");

        // R6: live capture with nonzero high byte
        repeat (700) @(negedge clk);
        rd(3'd4, v);
        peek(3'd5, hi);
        check("R6", hi, m_read(5), "captured high byte");
        check("R6", (hi != 0) ? 1 : 0, 1, "high byte nonzero");

        // R11: capture disabled, start kept
        wr(3'd1, 8'h01);
        rd(3'd4, v);
        check("R11", v, 0, "capture low with enable clear");
        peek(3'd5, v);
        check("R11", v, hi, "capture high untouched");

        // R8 / R4: stop with bit1 clear keeps enable
        wr(3'd1, 8'h03);
        wr(3'd1, 8'h00);
        peek(3'd1, v);
        check("R8", v, 8'h02, "enable kept on stop");
        check("R4", v % 2, 0, "stopped");
        peek(3'd4, v);
        check("R4", v, 0, "capture low after stop");
        peek(3'd5, v);
        check("R7", v, m_read(5), "high byte retained");
        rd(3'd4, v);
        check("R7", v, 0, "stopped low read");
        peek(3'd5, v);
        check("R7", v, 0, "high byte cleared");

        // R9: two-byte compare commit
        wr(3'd2, 8'h04);
        peek(3'd2, v);
        check("R9", v, 8'hFF, "low not committed");
        wr(3'd3, 8'h00);
        peek(3'd2, v);
        check("R9", v, 8'h04, "low committed");
        peek(3'd3, v);
        check("R9", v, 8'h00, "high committed");

        // R3: matches at div 2, compare 4
        wr(3'd1, 8'h01);
        repeat (80) @(negedge clk);
        wr(3'd1, 8'h00);

        // R2: div 64, compare 2
        wr(3'd0, 8'h01);
        wr(3'd2, 8'h02);
        wr(3'd3, 8'h00);
        wr(3'd1, 8'h03);
        repeat (800) @(negedge clk);
        wr(3'd1, 8'h00);

        // R2: div 1024, compare 1
        wr(3'd0, 8'h00);
        wr(3'd2, 8'h01);
        wr(3'd3, 8'h00);
        wr(3'd1, 8'h03);
        repeat (4500) @(negedge clk);
        wr(3'd1, 8'h00);

        // R2: slow source, compare 2
        slow_sel = 1'b1;
        wr(3'd2, 8'h02);
        wr(3'd3, 8'h00);
        wr(3'd1, 8'h03);
        repeat (400) @(negedge clk);
        rd(3'd4, v);
        wr(3'd1, 8'h00);
        slow_sel = 1'b0;

        // R5: non-timer op code blocks start, code 001 allows it
        wr(3'd0, 8'h0B);
        wr(3'd1, 8'h01);
        peek(3'd1, v);
        check("R5", v % 2, 0, "start refused for op 010");
        wr(3'd0, 8'h07);
        wr(3'd1, 8'h01);
        peek(3'd1, v);
        check("R5", v % 2, 1, "start accepted for op 001");
        repeat (40) @(negedge clk);
        wr(3'd1, 8'h00);

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule